// File: doc/BRIEF.md
# Register Operate Unit

This unit carries out the combinable register-operate instructions of a 17-bit accumulator machine. Each instruction word acts on one of two working registers, A or B, which bit B10 selects. Several micro-operations packed into one word are applied in a fixed order. The unit returns the updated registers, the carry and greater-than flags, and a skip decision that the sequencer uses to step over the next instruction.

Four instruction families are decoded. Bits B17:B11 pick the family for the three operate groups (octal 002xxx/003xxx, 004xxx/005xxx and 006xxx/007xxx). A word with B17:B11 clear and B9 set is a counted shift/rotate. Any other word leaves both registers and both flags as they were and never skips. The results are registered, so they appear one clock after the inputs are sampled. Reset is asynchronous and active low, and its release is synchronised.

Top module: `reg_op_unit`

## Requirements
- R1: Bit B10 (mask 001000) set targets A and clear targets B; the other register always keeps its value. A word outside the four families leaves A, B, carry and GT unchanged, with skip low.
- R2: In group 1, the 0400 bit clears carry first. A single shift or rotate then acts on B16:B1 only, with B17 unchanged. The 0200 bit selects left. 0040 is rotate, 0100 is shift, and 0060 is rotate through carry, where carry is part of the loop.
- R3: In group 1, INC (0004) and DEC (0010) wrap modulo 2^17 and leave carry alone. When both are set only INC acts. When 0100 and 0040 are both set, the instruction shifts and does not rotate.
- R4: Group 1 skip tests look at the result after all operations. 0001 skips when B1=0 and 0002 skips when B16=0. When both are set, either condition is enough.
- R5: Group 2 applies its operations in this order: 0040 complements carry, 0020 skips unconditionally, 0010 swaps B16:B9 with B8:B1, 0004 clears B17, 0002 complements B17, and 0001 loads the switch value.
- R6: Group 3 tests the incoming register and flags. 0200 tests B17, 0100 tests for a nonzero register, 0040 tests carry and 0010 tests GT, each against the sense bit 0400. Skip happens only when every selected test passes.
- R7: After its tests, group 3 clears GT (0004), then clears the register (0002), then ones-complements it (0001).
- R8: In the counted group, bits B8:B7 select rotate right (00), shift right (01), rotate left (10) or shift left (11), and B4:B1 give a count n from 0 to 15. With shift right, B5 set makes the shift arithmetic: vacated bits copy B17. B17, carry and GT stay unchanged, and skip is low.
- R9: While reset is asserted, A, B, carry, GT and skip all read zero. Asserting reset clears them immediately.
- R10: Outputs change only on the clock edge after the inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 17 | Instruction word |
| a_i | input | 17 | Current A register |
| b_i | input | 17 | Current B register |
| cf_i | input | 1 | Current carry flag |
| gt_i | input | 1 | Current greater-than flag |
| sw_i | input | 17 | Switch register value |
| a_o | output | 17 | Updated A register |
| b_o | output | 17 | Updated B register |
| cf_o | output | 1 | Updated carry flag |
| gt_o | output | 1 | Updated greater-than flag |
| skip_o | output | 1 | Skip-next-instruction decision |

## Verification
The bench targets the order of combined micro-operations:
- Clear-carry followed by a rotate through carry. If the order were reversed, the old carry would enter the register.
- Clear-sign followed by complement-sign. Getting this order wrong would clear the sign instead of setting it.
- Clear followed by complement. Getting this order wrong would leave zero.
- A test-for-nonzero combined with clear. A design that tested after clearing would never skip.

It also covers the ORed LSB/MSB skip against the ANDed group 3 tests, and INC/DEC wrap at the word limits. Counted shifts are run at n=0 and n=15. The arithmetic right shift is run with each sign, because filling from B16 instead of B17 changes the result. The collision cases (INC with DEC, shift with rotate) are checked for their fixed precedence.

// File: rtl/rop_pkg.sv
package rop_pkg;
  localparam int SEL_BIT  = 9;   // B10: target register select
  localparam int FAM_LSB  = 10;  // B11 upward: family field
  localparam int CNT_BIT  = 8;   // B9: counted shift group marker

  typedef enum logic [2:0] {
    FAM_NONE  = 3'd0,
    FAM_G1    = 3'd1,
    FAM_G2    = 3'd2,
    FAM_G3    = 3'd3,
    FAM_CNT   = 3'd4
  } fam_e;
endpackage

// File: rtl/rop_grp1.sv
module rop_grp1 #(
  parameter int W = 17
) (
  input  logic [W-1:0] op_i,
  input  logic [W-1:0] x_i,
  input  logic         c_i,
  output logic [W-1:0] x_o,
  output logic         c_o,
  output logic         skip_o
);
  localparam int D = W - 1;

  logic [D-1:0] d;
  logic [W-1:0] y;
  logic         c;

  always_comb begin
    c = op_i[8] ? 1'b0 : c_i;
    d = x_i[D-1:0];
    if (op_i[6]) begin
      d = op_i[7] ? {d[D-2:0], 1'b0} : {1'b0, d[D-1:1]};
    end else if (op_i[5]) begin
      if (op_i[4]) begin
        if (op_i[7]) begin
          d = {d[D-2:0], c};
          c = x_i[D-1];
        end else begin
          d = {c, d[D-1:1]};
          c = x_i[0];
        end
      end else begin
        d = op_i[7] ? {d[D-2:0], d[D-1]} : {d[0], d[D-1:1]};
      end
    end
    y = {x_i[W-1], d};
    if (op_i[2])      y = y + 1'b1;
    else if (op_i[3]) y = y - 1'b1;
    x_o    = y;
    c_o    = c;
    skip_o = (op_i[1] & ~y[D-1]) | (op_i[0] & ~y[0]);
  end
endmodule

// File: rtl/rop_grp2.sv
module rop_grp2 #(
  parameter int W = 17
) (
  input  logic [W-1:0] op_i,
  input  logic [W-1:0] x_i,
  input  logic         c_i,
  input  logic [W-1:0] sw_i,
  output logic [W-1:0] x_o,
  output logic         c_o,
  output logic         skip_o
);
  localparam int D = W - 1;
  localparam int H = D / 2;

  always_comb begin
    c_o    = op_i[5] ? ~c_i : c_i;
    skip_o = op_i[4];
    x_o    = x_i;
    if (op_i[3]) x_o = {x_i[W-1], x_i[H-1:0], x_i[D-1:H]};
    if (op_i[2]) x_o[W-1] = 1'b0;
    if (op_i[1]) x_o[W-1] = ~x_o[W-1];
    if (op_i[0]) x_o = sw_i;
  end
endmodule

// File: rtl/rop_grp3.sv
module rop_grp3 #(
  parameter int W = 17
) (
  input  logic [W-1:0] op_i,
  input  logic [W-1:0] x_i,
  input  logic         c_i,
  input  logic         gt_i,
  output logic [W-1:0] x_o,
  output logic         gt_o,
  output logic         skip_o
);
  logic sense, any_test, all_ok;

  always_comb begin
    sense    = op_i[8];
    any_test = op_i[7] | op_i[6] | op_i[5] | op_i[3];
    all_ok   = (~op_i[7] | (x_i[W-1] == sense))
             & (~op_i[6] | ((|x_i) == sense))
             & (~op_i[5] | (c_i == sense))
             & (~op_i[3] | (gt_i == sense));
    skip_o   = any_test & all_ok;
    gt_o     = op_i[2] ? 1'b0 : gt_i;
    x_o      = op_i[1] ? '0 : x_i;
    if (op_i[0]) x_o = ~x_o;
  end
endmodule

// File: rtl/rop_multi.sv
module rop_multi #(
  parameter int W = 17
) (
  input  logic [W-1:0] op_i,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] x_o
);
  localparam int D = W - 1;

  logic [2*D-1:0] wide;
  logic [D-1:0]   d, r;
  logic [3:0]     n;

  always_comb begin
    d    = x_i[D-1:0];
    n    = op_i[3:0];
    wide = '0;
    unique case (op_i[7:6])
      2'b00: begin
        wide = {d, d} >> n;
        r    = wide[D-1:0];
      end
      2'b01: begin
        wide = (op_i[4] ? {{D{x_i[W-1]}}, d} : {{D{1'b0}}, d}) >> n;
        r    = wide[D-1:0];
      end
      2'b10: begin
        wide = {d, d} << n;
        r    = wide[2*D-1:D];
      end
      default: r = d << n;
    endcase
    x_o = {x_i[W-1], r};
  end
endmodule

// File: rtl/reg_op_unit.sv
module reg_op_unit
  import rop_pkg::*;
#(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cf_i,
  input  logic         gt_i,
  input  logic [W-1:0] sw_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         cf_o,
  output logic         gt_o,
  output logic         skip_o
);
  localparam int FW = W - FAM_LSB;

  // reset release synchroniser
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // family decode
  fam_e fam;
  logic [FW-1:0] fam_f;
  assign fam_f = op_i[W-1:FAM_LSB];
  always_comb begin
    if (fam_f == FW'(1))                          fam = FAM_G1;
    else if (fam_f == FW'(2))                     fam = FAM_G2;
    else if (fam_f == FW'(3))                     fam = FAM_G3;
    else if (fam_f == '0 && op_i[CNT_BIT])        fam = FAM_CNT;
    else                                          fam = FAM_NONE;
  end

  logic         sel_a;
  logic [W-1:0] x_sel;
  assign sel_a = op_i[SEL_BIT];
  assign x_sel = sel_a ? a_i : b_i;

  logic [W-1:0] x1, x2, x3, xm;
  logic         c1, c2, g3, s1, s2, s3;

  rop_grp1  #(.W(W)) g1_i (.op_i(op_i), .x_i(x_sel), .c_i(cf_i),
                           .x_o(x1), .c_o(c1), .skip_o(s1));
  rop_grp2  #(.W(W)) g2_i (.op_i(op_i), .x_i(x_sel), .c_i(cf_i), .sw_i(sw_i),
                           .x_o(x2), .c_o(c2), .skip_o(s2));
  rop_grp3  #(.W(W)) g3_i (.op_i(op_i), .x_i(x_sel), .c_i(cf_i), .gt_i(gt_i),
                           .x_o(x3), .gt_o(g3), .skip_o(s3));
  rop_multi #(.W(W)) gm_i (.op_i(op_i), .x_i(x_sel), .x_o(xm));

  // next-state
  logic [W-1:0] x_n, a_n, b_n;
  logic         c_n, g_n, s_n;
  always_comb begin
    x_n = x_sel;
    c_n = cf_i;
    g_n = gt_i;
    s_n = 1'b0;
    unique case (fam)
      FAM_G1:  begin x_n = x1; c_n = c1; s_n = s1; end
      FAM_G2:  begin x_n = x2; c_n = c2; s_n = s2; end
      FAM_G3:  begin x_n = x3; g_n = g3; s_n = s3; end
      FAM_CNT: begin x_n = xm; end
      default: ;
    endcase
    a_n = sel_a ? x_n : a_i;
    b_n = sel_a ? b_i : x_n;
  end

  // state registers, loaded every cycle
  logic ld_en;
  assign ld_en = 1'b1;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      a_o    <= '0;
      b_o    <= '0;
      cf_o   <= 1'b0;
      gt_o   <= 1'b0;
      skip_o <= 1'b0;
    end else if (ld_en) begin
      a_o    <= a_n;
      b_o    <= b_n;
      cf_o   <= c_n;
      gt_o   <= g_n;
      skip_o <= s_n;
    end
  end

  // assertions
  a_r1_b_kept: assert property (@(posedge clk) disable iff (!rst_q)
    op_i[SEL_BIT] |=> b_o == $past(b_i));
  a_r1_a_kept: assert property (@(posedge clk) disable iff (!rst_q)
    !op_i[SEL_BIT] |=> a_o == $past(a_i));
  a_r1_other_quiet: assert property (@(posedge clk) disable iff (!rst_q)
    (fam == FAM_NONE) |=> (!skip_o && cf_o == $past(cf_i) && a_o == $past(a_i)));
  a_r8_cnt_flags: assert property (@(posedge clk) disable iff (!rst_q)
    (fam == FAM_CNT) |=> (!skip_o && cf_o == $past(cf_i) && gt_o == $past(gt_i)));
  a_r8_cnt_sign: assert property (@(posedge clk) disable iff (!rst_q)
    (fam == FAM_CNT && op_i[SEL_BIT]) |=> a_o[W-1] == $past(a_i[W-1]));
  a_r2_sign_kept: assert property (@(posedge clk) disable iff (!rst_q)
    (fam == FAM_G1 && (op_i[6] | op_i[5]) && !op_i[2] && !op_i[3] && op_i[SEL_BIT])
      |=> a_o[W-1] == $past(a_i[W-1]));
  a_r6_gt_only_g3: assert property (@(posedge clk) disable iff (!rst_q)
    (fam != FAM_G3) |=> gt_o == $past(gt_i));
endmodule

// File: tb/reg_op_unit_tb.sv
module reg_op_unit_tb_top;
  localparam int W = 17;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] op_i, a_i, b_i, sw_i;
  logic         cf_i, gt_i;
  logic [W-1:0] a_o, b_o;
  logic         cf_o, gt_o, skip_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  reg_op_unit #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .cf_i(cf_i), .gt_i(gt_i), .sw_i(sw_i),
    .a_o(a_o), .b_o(b_o), .cf_o(cf_o), .gt_o(gt_o), .skip_o(skip_o));

  typedef struct packed {
    logic [W-1:0] op, a, b;
    logic         c, g;
    logic [W-1:0] ea, eb;
    logic         ec, eg, es;
    logic [7:0]   rq;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{17'o000000, 17'o123456, 17'o054321, 1'b1, 1'b1, 17'o123456, 17'o054321, 1'b1, 1'b1, 1'b0, 8'd1}, // R1
    '{17'o010000, 17'o000007, 17'o000003, 1'b0, 1'b1, 17'o000007, 17'o000003, 1'b0, 1'b1, 1'b0, 8'd1}, // R1
    '{17'o003300, 17'o300001, 17'o054321, 1'b1, 1'b0, 17'o200002, 17'o054321, 1'b1, 1'b0, 1'b0, 8'd2}, // R2
    '{17'o002060, 17'o111111, 17'o000001, 1'b0, 1'b0, 17'o111111, 17'o000000, 1'b1, 1'b0, 1'b0, 8'd2}, // R2
    '{17'o003660, 17'o100000, 17'o000000, 1'b1, 1'b0, 17'o000000, 17'o000000, 1'b1, 1'b0, 1'b0, 8'd2}, // R2
    '{17'o003240, 17'o300000, 17'o000000, 1'b0, 1'b0, 17'o200001, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd2}, // R2
    '{17'o003004, 17'o377777, 17'o000000, 1'b1, 1'b0, 17'o000000, 17'o000000, 1'b1, 1'b0, 1'b0, 8'd3}, // R3
    '{17'o002010, 17'o000000, 17'o000000, 1'b0, 1'b0, 17'o000000, 17'o377777, 1'b0, 1'b0, 1'b0, 8'd3}, // R3
    '{17'o003014, 17'o000005, 17'o000000, 1'b0, 1'b0, 17'o000006, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd3}, // R3
    '{17'o003140, 17'o000003, 17'o000000, 1'b0, 1'b0, 17'o000001, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd3}, // R3
    '{17'o003001, 17'o000002, 17'o000000, 1'b0, 1'b0, 17'o000002, 17'o000000, 1'b0, 1'b0, 1'b1, 8'd4}, // R4
    '{17'o003002, 17'o100000, 17'o000000, 1'b0, 1'b0, 17'o100000, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd4}, // R4
    '{17'o003003, 17'o100000, 17'o000000, 1'b0, 1'b0, 17'o100000, 17'o000000, 1'b0, 1'b0, 1'b1, 8'd4}, // R4
    '{17'o003003, 17'o100001, 17'o000000, 1'b0, 1'b0, 17'o100001, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd4}, // R4
    '{17'o003005, 17'o000001, 17'o000000, 1'b0, 1'b0, 17'o000002, 17'o000000, 1'b0, 1'b0, 1'b1, 8'd4}, // R4
    '{17'o005006, 17'o012345, 17'o000000, 1'b0, 1'b0, 17'o212345, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd5}, // R5
    '{17'o004010, 17'o000000, 17'o212345, 1'b0, 1'b0, 17'o000000, 17'o362424, 1'b0, 1'b0, 1'b0, 8'd5}, // R5
    '{17'o005003, 17'o000000, 17'o000000, 1'b0, 1'b0, 17'o070707, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd5}, // R5
    '{17'o004060, 17'o000000, 17'o000001, 1'b0, 1'b0, 17'o000000, 17'o000001, 1'b1, 1'b0, 1'b1, 8'd5}, // R5
    '{17'o007502, 17'o000400, 17'o000000, 1'b0, 1'b0, 17'o000000, 17'o000000, 1'b0, 1'b0, 1'b1, 8'd6}, // R6
    '{17'o007502, 17'o000000, 17'o000000, 1'b0, 1'b0, 17'o000000, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd6}, // R6
    '{17'o007600, 17'o200000, 17'o000000, 1'b0, 1'b0, 17'o200000, 17'o000000, 1'b0, 1'b0, 1'b1, 8'd6}, // R6
    '{17'o007200, 17'o200000, 17'o000000, 1'b0, 1'b0, 17'o200000, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd6}, // R6
    '{17'o006450, 17'o000000, 17'o000000, 1'b1, 1'b0, 17'o000000, 17'o000000, 1'b1, 1'b0, 1'b0, 8'd6}, // R6
    '{17'o006450, 17'o000000, 17'o000000, 1'b1, 1'b1, 17'o000000, 17'o000000, 1'b1, 1'b1, 1'b1, 8'd6}, // R6
    '{17'o007003, 17'o000123, 17'o000000, 1'b0, 1'b0, 17'o377777, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd7}, // R7
    '{17'o006004, 17'o000000, 17'o000042, 1'b0, 1'b1, 17'o000000, 17'o000042, 1'b0, 1'b0, 1'b0, 8'd7}, // R7
    '{17'o001403, 17'o200007, 17'o000000, 1'b0, 1'b0, 17'o360000, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd8}, // R8
    '{17'o000505, 17'o000000, 17'o177777, 1'b0, 1'b0, 17'o000000, 17'o003777, 1'b0, 1'b0, 1'b0, 8'd8}, // R8
    '{17'o001524, 17'o300000, 17'o000000, 1'b0, 1'b0, 17'o374000, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd8}, // R8
    '{17'o000524, 17'o000000, 17'o100000, 1'b0, 1'b0, 17'o000000, 17'o004000, 1'b0, 1'b0, 1'b0, 8'd8}, // R8
    '{17'o001617, 17'o000001, 17'o000000, 1'b1, 1'b1, 17'o100000, 17'o000000, 1'b1, 1'b1, 1'b0, 8'd8}, // R8
    '{17'o000700, 17'o000000, 17'o012345, 1'b1, 1'b0, 17'o000000, 17'o012345, 1'b1, 1'b0, 1'b0, 8'd8}, // R8
    '{17'o001717, 17'o000003, 17'o000000, 1'b0, 1'b0, 17'o100000, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd8}, // R8
    '{17'o001603, 17'o100001, 17'o000000, 1'b0, 1'b0, 17'o000014, 17'o000000, 1'b0, 1'b0, 1'b0, 8'd8}  // R8
  };

  task automatic check_out(input string tag, input logic [W-1:0] ea, eb,
                           input logic ec, eg, es);
    total++;
    if (a_o !== ea || b_o !== eb || cf_o !== ec || gt_o !== eg || skip_o !== es) begin
      bad++;
      $display("FAIL %s: got a=%o b=%o c=%b gt=%b skip=%b, want a=%o b=%o c=%b gt=%b skip=%b",
               tag, a_o, b_o, cf_o, gt_o, skip_o, ea, eb, ec, eg, es);
    end
  endtask

  task automatic drive(input logic [W-1:0] op, a, b, input logic c, g);
    op_i = op; a_i = a; b_i = b; cf_i = c; gt_i = g;
  endtask

  initial begin
    rst_n = 1'b0;
    sw_i  = 17'o070707;
    drive(17'o000000, 17'o155555, 17'o022222, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    check_out("R9 reset state", '0, '0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].c, VEC[i].g);
      @(negedge clk);
      check_out($sformatf("R%0d vector %0d", VEC[i].rq, i),
                VEC[i].ea, VEC[i].eb, VEC[i].ec, VEC[i].eg, VEC[i].es);
    end

    // R10: new inputs must not reach the outputs before the edge
    drive(17'o000000, 17'o000011, 17'o000022, 1'b0, 1'b0);
    @(negedge clk);
    drive(17'o003004, 17'o000011, 17'o000022, 1'b0, 1'b0);
    #5;
    check_out("R10 before edge", 17'o000011, 17'o000022, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check_out("R10 after edge", 17'o000012, 17'o000022, 1'b0, 1'b0, 1'b0);

    // R9: reset asserted mid-run clears at once
    drive(17'o004060, 17'o000011, 17'o000022, 1'b0, 1'b1);
    @(negedge clk);
    check_out("R5 pre-reset", 17'o000011, 17'o000022, 1'b1, 1'b1, 1'b1);
    rst_n = 1'b0;
    #2;
    check_out("R9 async clear", '0, '0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R1 after reset release", 17'o000011, 17'o000022, 1'b1, 1'b1, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, got hung, want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule